// File: doc/BRIEF.md
# Serial-Input DAC Register Front End

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. An oversampling system clock samples three asynchronous control pins and one data pin: an active-low chip select, a serial clock, serial data and an active-low load strobe. Each pin passes through a two-stage synchronizer. Edges are then found in the system clock domain. While the chip is selected, each rising serial clock edge shifts one data bit into a shift register, most significant bit first.

A frame is valid only when it holds exactly the word width in bits. When chip select is released after a valid frame, the word goes into an input holding register. If the load strobe is low at that moment, the word also goes straight to the DAC code output. If the load strobe is high, the word stays in the holding register. It reaches the output on the next falling edge of the load strobe, provided that edge comes while the chip is deselected. A falling load strobe while the chip is selected is illegal: it raises an error flag and spoils the frame in progress.

Low-power shutdown is entered by a pin pattern, not by a command: a change of serial clock level followed by two chip-select falls with no clock change between them. The block leaves shutdown on a chip-select fall or on any serial clock change. A ready flag then stays low for a parameterized settling count.

Top module: `sdac_core`

## Requirements
- R1: Data is sampled on each synchronized rising serial clock edge while chip select is low, shifting left so the first bit received becomes the most significant bit of the word. Two 8-bit bursts in one select window form one word.
- R2: Every falling chip-select edge clears the bit count and the shift register, so a frame aborted earlier has no effect on the next frame.
- R3: When chip select rises after exactly WORD_W bits and the load strobe is low, `dac_code_o` takes the received word.
- R4: When chip select rises after fewer or more than WORD_W bits, the word is dropped, and both the holding register and `dac_code_o` keep their values.
- R5: When the load strobe is high as chip select rises after a valid frame, `dac_code_o` is unchanged. A later falling load strobe while chip select is high copies the held word to `dac_code_o`.
- R6: A falling load strobe while chip select is low moves nothing to the output. It sets `ldac_err_o`, which stays high until the next chip-select fall, and the frame in progress is dropped even if it is complete.
- R7: After a serial clock level change in either direction, two chip-select falls with no clock change between them set `shutdown_o` and clear `ready_o`. The normal frame traffic never does so.
- R8: `shutdown_o` stays high while neither a chip-select fall nor a serial clock change occurs. A chip-select rise does not end shutdown.
- R9: A chip-select fall or a serial clock change during shutdown clears `shutdown_o`. `ready_o` then stays low for WAKE_CYCLES system clocks before it rises.
- R10: After reset, `dac_code_o` is 16'h8000 when MIDSCALE_RESET is 1 and 16'h0000 when it is 0. `shutdown_o` and `ldac_err_o` are 0 and `ready_o` is 1.
- R11: Entering and leaving shutdown leaves `dac_code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data, MSB first |
| ldac_n_i | input | 1 | Load strobe, active low, asynchronous |
| dac_code_o | output | WORD_W | Code applied to the converter |
| shutdown_o | output | 1 | High while in low-power shutdown |
| ready_o | output | 1 | High once wake-up settling has finished |
| ldac_err_o | output | 1 | Load strobe fell while chip select was low |

## Verification
Corrupted shift or count state shows as a wrong code, or as a missing code change, on `dac_code_o` about four system clocks after the chip-select rise that ends the frame. The scoreboard catches both, because every accepted frame carries a code that differs from the one before. A wrong shutdown sequencer state shows within four clocks of the second chip-select fall, as a missing or early `shutdown_o`. A wrong settling counter shows as `ready_o` rising too soon or too late, measured against the WAKE_CYCLES window. An error flag that is not cleared or not set shows on `ldac_err_o` right after the offending load-strobe edge, and again as a dropped or wrongly accepted next word.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_LDAC = 3;
    localparam int PIN_N    = 4;

    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,   // no clock change seen yet
        PM_ARM0 = 2'd1,   // clock changed, no select fall since
        PM_ARM1 = 2'd2,   // clock changed, one select fall since
        PM_SHDN = 2'd3    // low-power shutdown
    } pm_state_e;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pin_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o = r_q.s2;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fall_i,
    input  logic              sel_i,
    input  logic              bit_stb_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o
);
    localparam int            CW       = $clog2(WORD_W + 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(WORD_W);
    localparam logic [CW-1:0] OVER_CNT = CW'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } shift_t;

    shift_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel_fall_i) begin
            r_d.sh  = '0;
            r_d.cnt = '0;
        end else if (sel_i && bit_stb_i) begin
            r_d.sh = {r_q.sh[WORD_W-2:0], din_i};
            if (r_q.cnt != OVER_CNT) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o = r_q.sh;
    assign full_o = (r_q.cnt == FULL_CNT);
endmodule

// File: rtl/sdac_power.sv
module sdac_power
    import sdac_pkg::*;
#(
    parameter int WAKE_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fall_i,
    input  logic sclk_chg_i,
    output logic shutdown_o,
    output logic ready_o
);
    localparam int            WW      = $clog2(WAKE_CYCLES + 1);
    localparam logic [WW-1:0] WAKE_LD = WW'(WAKE_CYCLES);

    typedef struct packed {
        pm_state_e     st;
        logic [WW-1:0] wcnt;
    } pwr_t;

    pwr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.wcnt != '0) begin
            r_d.wcnt = r_q.wcnt - 1'b1;
        end
        unique case (r_q.st)
            PM_IDLE: begin
                if (sclk_chg_i) r_d.st = PM_ARM0;
            end
            PM_ARM0: begin
                if (sclk_chg_i)      r_d.st = PM_ARM0;
                else if (sel_fall_i) r_d.st = PM_ARM1;
            end
            PM_ARM1: begin
                if (sclk_chg_i) begin
                    r_d.st = PM_ARM0;
                end else if (sel_fall_i) begin
                    r_d.st   = PM_SHDN;
                    r_d.wcnt = '0;
                end
            end
            PM_SHDN: begin
                r_d.wcnt = '0;
                if (sclk_chg_i) begin
                    r_d.st   = PM_ARM0;
                    r_d.wcnt = WAKE_LD;
                end else if (sel_fall_i) begin
                    r_d.st   = PM_IDLE;
                    r_d.wcnt = WAKE_LD;
                end
            end
            default: r_d.st = PM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PM_IDLE;
            r_q.wcnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shutdown_o = (r_q.st == PM_SHDN);
    assign ready_o    = (r_q.st != PM_SHDN) && (r_q.wcnt == '0);
endmodule

// File: rtl/sdac_core.sv
module sdac_core
    import sdac_pkg::*;
#(
    parameter int WORD_W         = 16,
    parameter int WAKE_CYCLES    = 2500,
    parameter bit MIDSCALE_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic              ldac_n_i,
    output logic [WORD_W-1:0] dac_code_o,
    output logic              shutdown_o,
    output logic              ready_o,
    output logic              ldac_err_o
);
    localparam logic [WORD_W-1:0] RST_CODE =
        MIDSCALE_RESET ? {1'b1, {(WORD_W-1){1'b0}}} : '0;
    localparam logic [PIN_N-1:0]  PIN_IDLE = PIN_N'(4'b1001);

    typedef struct packed {
        logic              cs_p;
        logic              sclk_p;
        logic              ldac_p;
        logic              err;
        logic [WORD_W-1:0] latch;
        logic [WORD_W-1:0] dac;
    } core_t;

    core_t r_d, r_q;

    logic [PIN_N-1:0]  pin_lvl;
    logic              cs_hi, sclk_lvl, din_lvl, ldac_lvl;
    logic              cs_fall, cs_rise, sclk_rise, sclk_chg, ldac_fall;
    logic [WORD_W-1:0] word;
    logic              word_full;
    logic              frame_ok;

    sdac_pin_sync #(
        .W       (PIN_N),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ldac_n_i, din_i, sclk_i, cs_n_i}),
        .lvl_o (pin_lvl)
    );

    assign cs_hi     = pin_lvl[PIN_CS];
    assign sclk_lvl  = pin_lvl[PIN_SCLK];
    assign din_lvl   = pin_lvl[PIN_DIN];
    assign ldac_lvl  = pin_lvl[PIN_LDAC];

    assign cs_fall   = r_q.cs_p & ~cs_hi;
    assign cs_rise   = ~r_q.cs_p & cs_hi;
    assign sclk_rise = ~r_q.sclk_p & sclk_lvl;
    assign sclk_chg  = r_q.sclk_p ^ sclk_lvl;
    assign ldac_fall = r_q.ldac_p & ~ldac_lvl;

    sdac_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_fall_i (cs_fall),
        .sel_i      (~cs_hi),
        .bit_stb_i  (sclk_rise),
        .din_i      (din_lvl),
        .word_o     (word),
        .full_o     (word_full)
    );

    sdac_power #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_fall_i (cs_fall),
        .sclk_chg_i (sclk_chg),
        .shutdown_o (shutdown_o),
        .ready_o    (ready_o)
    );

    assign frame_ok = cs_rise & word_full & ~r_q.err;

    always_comb begin
        r_d        = r_q;
        r_d.cs_p   = cs_hi;
        r_d.sclk_p = sclk_lvl;
        r_d.ldac_p = ldac_lvl;

        if (cs_fall) begin
            r_d.err = 1'b0;
        end else if (ldac_fall && !cs_hi) begin
            r_d.err = 1'b1;
        end

        if (frame_ok) begin
            r_d.latch = word;
        end

        if (frame_ok && !ldac_lvl) begin
            r_d.dac = word;
        end else if (ldac_fall && cs_hi) begin
            r_d.dac = r_q.latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cs_p   <= PIN_IDLE[PIN_CS];
            r_q.sclk_p <= PIN_IDLE[PIN_SCLK];
            r_q.ldac_p <= PIN_IDLE[PIN_LDAC];
            r_q.err    <= 1'b0;
            r_q.latch  <= RST_CODE;
            r_q.dac    <= RST_CODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code_o = r_q.dac;
    assign ldac_err_o = r_q.err;
endmodule

// File: rtl/sdac_core_chk.sv
module sdac_core_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_hi,
    input logic              cs_fall,
    input logic              sclk_chg,
    input logic [WORD_W-1:0] dac_code,
    input logic              shutdown,
    input logic              ready,
    input logic              err
);
    // R3 / R5: the output code only moves while the chip is deselected
    a_r5_code_moves_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(cs_hi));

    // R6: the error flag rises only from an event seen with the chip selected
    a_r6_err_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !$past(cs_hi));

    // R7: shutdown never reports ready
    a_r7_shdn_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !ready);

    // R7: shutdown is entered on a chip-select fall
    a_r7_entry_on_sel_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(cs_fall));

    // R8: shutdown persists without a wake event
    a_r8_hold_static: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !cs_fall && !sclk_chg) |=> shutdown);

    // R9: leaving shutdown starts with ready low
    a_r9_wake_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> !ready);

    // R9: leaving shutdown needs a wake event
    a_r9_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> ($past(cs_fall) || $past(sclk_chg)));

    // R11: shutdown entry and exit leave the code alone
    a_r11_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shutdown) || $fell(shutdown)) |-> $stable(dac_code));
endmodule

bind sdac_core sdac_core_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_hi    (cs_hi),
    .cs_fall  (cs_fall),
    .sclk_chg (sclk_chg),
    .dac_code (dac_code_o),
    .shutdown (shutdown_o),
    .ready    (ready_o),
    .err      (ldac_err_o)
);

// File: tb/sdac_core_tb.sv
`timescale 1ns/1ps
module sdac_core_tb_top;
    localparam int WORD_W = 16;
    localparam int WAKE   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b0;
    logic              din = 1'b0;
    logic              ldac_n = 1'b1;
    logic [WORD_W-1:0] dac_code;
    logic              shutdown, ready, ldac_err;

    int                n_chk = 0;
    int                n_err = 0;
    bit                mon_en = 1'b0;
    bit                done = 1'b0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] mon_last;

    always #10 clk = ~clk;

    sdac_core #(
        .WORD_W         (WORD_W),
        .WAKE_CYCLES    (WAKE),
        .MIDSCALE_RESET (1'b1)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .din_i      (din),
        .ldac_n_i   (ldac_n),
        .dac_code_o (dac_code),
        .shutdown_o (shutdown),
        .ready_o    (ready),
        .ldac_err_o (ldac_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din = v[i];
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        tick(4);
        send_bits(v, n);
        tick(4);
        cs_n = 1'b1;
        tick(12);
    endtask

    task automatic cs_pulse();
        cs_n = 1'b0;
        tick(8);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // scoreboard monitor: each code change must match the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && dac_code !== mon_last) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R3/R5 scoreboard unexpected code actual=%h expected=none", dac_code);
                end else begin
                    logic [WORD_W-1:0] e;
                    e = exp_q.pop_front();
                    if (dac_code !== e) begin
                        n_err++;
                        $display("FAIL R3/R5 scoreboard actual=%h expected=%h", dac_code, e);
                    end
                end
                mon_last = dac_code;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(6);
        // R10: reset state
        chk("R10 code", 32'(dac_code), 32'h8000);
        chk("R10 shutdown", 32'(shutdown), 32'h0);
        chk("R10 ready", 32'(ready), 32'h1);
        chk("R10 err", 32'(ldac_err), 32'h0);
        mon_last = dac_code;
        mon_en   = 1'b1;

        // immediate mode: strobe held low
        ldac_n = 1'b0;
        tick(10);
        exp_q.push_back(16'h1234);
        frame(32'h1234, 16);
        chk("R3 immediate", 32'(dac_code), 32'h1234);

        // R1: two byte bursts, no gap
        exp_q.push_back(16'hA5C3);
        frame(32'hA5C3, 16);
        chk("R1 two bytes msb first", 32'(dac_code), 32'hA5C3);

        // R4: short and long frames dropped
        frame(32'h00FF, 8);
        chk("R4 short frame", 32'(dac_code), 32'hA5C3);
        frame(32'h1BEEF, 17);
        chk("R4 long frame", 32'(dac_code), 32'hA5C3);

        // R2: aborted frame then a full one
        frame(32'h1F, 5);
        exp_q.push_back(16'h5A69);
        frame(32'h5A69, 16);
        chk("R2 count cleared", 32'(dac_code), 32'h5A69);

        // R5: deferred update
        ldac_n = 1'b1;
        tick(10);
        frame(32'h0F0F, 16);
        chk("R5 held", 32'(dac_code), 32'h5A69);
        exp_q.push_back(16'h0F0F);
        ldac_n = 1'b0;
        tick(10);
        chk("R5 strobe load", 32'(dac_code), 32'h0F0F);

        // R6: strobe falls during selection
        ldac_n = 1'b1;
        tick(10);
        cs_n = 1'b0;
        tick(4);
        send_bits(32'h7777, 16);
        ldac_n = 1'b0;
        tick(10);
        chk("R6 err set", 32'(ldac_err), 32'h1);
        chk("R6 no transfer while selected", 32'(dac_code), 32'h0F0F);
        cs_n = 1'b1;
        tick(12);
        chk("R6 frame dropped", 32'(dac_code), 32'h0F0F);
        chk("R6 err kept", 32'(ldac_err), 32'h1);
        exp_q.push_back(16'h3C3C);
        frame(32'h3C3C, 16);
        chk("R6 err cleared", 32'(ldac_err), 32'h0);
        chk("R6 next frame ok", 32'(dac_code), 32'h3C3C);
        chk("R7 frames no shutdown", 32'(shutdown), 32'h0);

        // R7: shutdown via clock change + two select falls
        sclk = 1'b1;
        tick(8);
        cs_pulse();
        chk("R7 one fall not enough", 32'(shutdown), 32'h0);
        cs_n = 1'b0;
        tick(8);
        chk("R7 shutdown", 32'(shutdown), 32'h1);
        chk("R7 not ready", 32'(ready), 32'h0);
        cs_n = 1'b1;
        tick(200);
        chk("R8 held static", 32'(shutdown), 32'h1);
        chk("R11 code kept", 32'(dac_code), 32'h3C3C);

        // R9: wake by select fall
        cs_n = 1'b0;
        tick(8);
        chk("R9 wake by select", 32'(shutdown), 32'h0);
        tick(20);
        chk("R9 settling", 32'(ready), 32'h0);
        cs_n = 1'b1;
        tick(70);
        chk("R9 ready after delay", 32'(ready), 32'h1);

        // second shutdown, wake by clock change
        sclk = 1'b0;
        tick(8);
        cs_pulse();
        cs_pulse();
        chk("R7 shutdown again", 32'(shutdown), 32'h1);
        sclk = 1'b1;
        tick(8);
        chk("R9 wake by clock", 32'(shutdown), 32'h0);
        tick(20);
        chk("R9 settling clock wake", 32'(ready), 32'h0);
        tick(70);
        chk("R9 ready clock wake", 32'(ready), 32'h1);
        chk("R11 code after wake", 32'(dac_code), 32'h3C3C);
        sclk = 1'b0;
        tick(8);

        exp_q.push_back(16'hBEEF);
        frame(32'hBEEF, 16);
        chk("R3 after wake", 32'(dac_code), 32'hBEEF);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule